// File: doc/BRIEF.md
# System Clock Mode Controller

This block turns two software-written 8-bit control registers into the processor bus-clock timing. The bus clock is not produced as a separate clock net. It appears as a one-cycle enable pulse, `bclk_en`, in the main-clock domain. The pulse rate is the main clock divided by 1, 2, 4, 8 or 16, or one pulse per rising edge of the slow sub-clock after that clock is synchronized. The block also drives the enable lines of the main and sub oscillators. It decides whether the main oscillator may stop.

A small power state machine has three states: ST_RUN, ST_HALT and ST_RESUME. The transitions are:

- ST_RUN to ST_HALT on a stop request.
- ST_HALT to ST_RESUME on a wake input.
- ST_RESUME to ST_RUN after one cycle.

On the ST_RUN to ST_HALT transition, the divide-by-8 bit of control register 0 is updated. How it is updated depends on whether a main-clock mode or a sub-clock mode was active.

The divider runs from a free counter. A new ratio or source is taken over only when the current bus-clock period completes. Oscillator stabilization and wake-up sources lie outside the block and arrive as plain inputs.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset, ctrl0_q reads 0x48 and ctrl1_q reads 0x00. The sub-oscillator enable is low and the main-oscillator enable is high. bclk_en pulses once every 8 cycles, with the first pulse in the 8th cycle after reset is released.
- R2: With ctrl0 bit 7 = 0, bit 6 = 1 and bit 5 = 0, bclk_en pulses every 8 cycles whatever ctrl1 bits 7:6 hold.
- R3: With ctrl0 bits 7, 6 and 5 all 0, ctrl1 bits 7:6 set the pulse period: 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 16.
- R4: With ctrl0 bit 7 = 1 and bit 4 = 1, bclk_en pulses once per rising edge of sub_clk_in, after a SYNC_STAGES-flop synchronizer and an edge detector. ctrl0 bit 6 and ctrl1 are ignored.
- R5: sub_osc_en follows ctrl0 bit 4. main_osc_en is low only when ctrl0 bits 7, 5 and 4 are all 1 (low-power mode). With bit 5 = 0 (low-speed mode) the main oscillator stays on. Both rules apply outside ST_HALT.
- R6: Encodings that name no mode fall back to a period of 8. These are ctrl0 bit 7 = 0 with bit 5 = 1, and ctrl0 bit 7 = 1 with bit 4 = 0.
- R7: A change of ratio or source takes effect only at the end of the current period, or at the next synchronized sub-clock edge when the sub-clock is the source. No pulse is doubled or cut short.
- R8: stop_req in ST_RUN enters ST_HALT. There, bclk_en, main_osc_en and sub_osc_en are all 0 until wake_in is seen. Then one ST_RESUME cycle follows, with the enables restored and no pulse. ST_RUN then resumes in the mode the registers indicate, with the period counter starting from zero.
- R9: Entering ST_HALT from a main-clock mode sets ctrl0 bit 6.
- R10: Entering ST_HALT from a sub-clock mode leaves ctrl0 unchanged.
- R11: A write with wr_en = 1 loads wr_data into ctrl0 when wr_sel = 0 and into ctrl1 when wr_sel = 1. The new value is visible on the matching output from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control register 0, 1 selects control register 1 |
| wr_data | input | 8 | Write data |
| sub_clk_in | input | 1 | Sub-clock, asynchronous to clk |
| stop_req | input | 1 | Request to enter stop |
| wake_in | input | 1 | Wake event ending stop |
| bclk_en | output | 1 | One-cycle bus-clock enable pulse |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| ctrl0_q | output | 8 | Control register 0 contents |
| ctrl1_q | output | 8 | Control register 1 contents |

## Verification
The bench builds the block with its default parameters: a two-stage sub-clock synchronizer and a 4-bit period counter. With these, the full ratio range up to 16 can be reached, and so can the exact two-cycle synchronizer latency on sub-clock edges. The reference model holds the synchronizer as a queue sized from the same stage count, so a change of that parameter is tracked without editing the model. Ratio changes are written in the middle of a period to reach the deferred switch. Stop is entered once from a sub-clock mode and once from a main-clock mode to reach both divide-by-8 bit outcomes.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    typedef enum logic [2:0] {
        MD_DIV1   = 3'd0,
        MD_DIV2   = 3'd1,
        MD_DIV4   = 3'd2,
        MD_DIV8   = 3'd3,
        MD_DIV16  = 3'd4,
        MD_SLOW   = 3'd5,
        MD_LOWPWR = 3'd6
    } bclk_mode_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_RESUME = 2'd2
    } pwr_state_e;

    // Register bit positions used by the decode.
    localparam int unsigned C0_SRC_SUB = 7;
    localparam int unsigned C0_DIV8    = 6;
    localparam int unsigned C0_MAINOFF = 5;
    localparam int unsigned C0_SUBON   = 4;

    function automatic bclk_mode_e decode_mode(input logic [7:0] c0, input logic [7:0] c1);
        bclk_mode_e m;
        if (c0[C0_SRC_SUB]) begin
            if (!c0[C0_SUBON])        m = MD_DIV8;
            else if (c0[C0_MAINOFF])  m = MD_LOWPWR;
            else                      m = MD_SLOW;
        end else if (c0[C0_MAINOFF] || c0[C0_DIV8]) begin
            m = MD_DIV8;
        end else begin
            unique case (c1[7:6])
                2'b00:   m = MD_DIV1;
                2'b01:   m = MD_DIV2;
                2'b10:   m = MD_DIV4;
                default: m = MD_DIV16;
            endcase
        end
        return m;
    endfunction

    function automatic logic mode_is_sub(input bclk_mode_e m);
        return (m == MD_SLOW) || (m == MD_LOWPWR);
    endfunction

    // Terminal count (period minus one) of a main-clock mode.
    function automatic logic [4:0] mode_term(input bclk_mode_e m);
        logic [4:0] t;
        unique case (m)
            MD_DIV1:  t = 5'd0;
            MD_DIV2:  t = 5'd1;
            MD_DIV4:  t = 5'd3;
            MD_DIV16: t = 5'd15;
            default:  t = 5'd7;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/sysclk_ctrl_regs.sv
module sysclk_ctrl_regs #(
    parameter int unsigned        REG_W  = 8,
    parameter logic [REG_W-1:0]   C0_RST = 8'h48,
    parameter logic [REG_W-1:0]   C1_RST = 8'h00,
    parameter int unsigned        DIV8_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             stop_enter,
    input  logic             from_main,
    output logic [REG_W-1:0] c0_q,
    output logic [REG_W-1:0] c1_q
);

    logic [REG_W-1:0] c0_d;

    always_comb begin
        c0_d = c0_q;
        if (wr_en && !wr_sel) begin
            c0_d = wr_data;
        end
        if (stop_enter && from_main) begin
            c0_d[DIV8_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c0_q <= C0_RST;
        end else begin
            c0_q <= c0_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_q <= C1_RST;
        end else if (wr_en && wr_sel) begin
            c1_q <= wr_data;
        end
    end

endmodule

// File: rtl/sysclk_sub_sync.sv
module sysclk_sub_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_raw,
    output logic rise_pulse
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= 1'b0;
        end else begin
            chain[0] <= sub_raw;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= 1'b0;
            end else begin
                chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain[STAGES-1];
        end
    end

    assign rise_pulse = chain[STAGES-1] && !last_q;

endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
    import sysclk_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  bclk_mode_e       mode_in,
    input  logic             sub_pulse,
    output logic             bclk_en,
    output logic             lat_sub,
    output logic [CNT_W-1:0] lat_term
);

    localparam logic [CNT_W-1:0] RST_TERM = CNT_W'(7);

    logic [CNT_W-1:0] cnt_q;
    logic             boundary;
    logic [CNT_W-1:0] next_term;

    assign next_term = CNT_W'(mode_term(mode_in));
    assign boundary  = lat_sub ? sub_pulse : (cnt_q == lat_term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            lat_term <= RST_TERM;
            lat_sub  <= 1'b0;
        end else if (!run || boundary) begin
            cnt_q    <= '0;
            lat_term <= next_term;
            lat_sub  <= mode_is_sub(mode_in);
        end else if (!lat_sub) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign bclk_en = run && boundary;

endmodule

// File: rtl/sysclk_pwr_fsm.sv
module sysclk_pwr_fsm
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake_in,
    output pwr_state_e state_q,
    output logic       stop_enter,
    output logic       osc_allow,
    output logic       div_run
);

    pwr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stop_req) state_d = ST_HALT;
            ST_HALT:   if (wake_in)  state_d = ST_RESUME;
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        stop_enter = 1'b0;
        osc_allow  = 1'b1;
        div_run    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                div_run    = 1'b1;
                stop_enter = stop_req;
            end
            ST_HALT:   osc_allow = 1'b0;
            ST_RESUME: osc_allow = 1'b1;
            default:   osc_allow = 1'b1;
        endcase
    end

endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
    import sysclk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4,
    parameter logic [7:0]  C0_RST      = 8'h48,
    parameter logic [7:0]  C1_RST      = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       sub_clk_in,
    input  logic       stop_req,
    input  logic       wake_in,
    output logic       bclk_en,
    output logic       main_osc_en,
    output logic       sub_osc_en,
    output logic [7:0] ctrl0_q,
    output logic [7:0] ctrl1_q
);

    pwr_state_e       st;
    logic             stop_enter;
    logic             osc_allow;
    logic             div_run;
    logic             sub_pulse;
    logic             lat_sub;
    logic [CNT_W-1:0] lat_term;
    bclk_mode_e       cur_mode;

    assign cur_mode = decode_mode(ctrl0_q, ctrl1_q);

    sysclk_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .wake_in    (wake_in),
        .state_q    (st),
        .stop_enter (stop_enter),
        .osc_allow  (osc_allow),
        .div_run    (div_run)
    );

    sysclk_ctrl_regs #(
        .REG_W    (8),
        .C0_RST   (C0_RST),
        .C1_RST   (C1_RST),
        .DIV8_BIT (C0_DIV8)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .stop_enter (stop_enter),
        .from_main  (!mode_is_sub(cur_mode)),
        .c0_q       (ctrl0_q),
        .c1_q       (ctrl1_q)
    );

    sysclk_sub_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sub_raw    (sub_clk_in),
        .rise_pulse (sub_pulse)
    );

    sysclk_ratio_div #(
        .CNT_W (CNT_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (div_run),
        .mode_in   (cur_mode),
        .sub_pulse (sub_pulse),
        .bclk_en   (bclk_en),
        .lat_sub   (lat_sub),
        .lat_term  (lat_term)
    );

    assign main_osc_en = osc_allow && (cur_mode != MD_LOWPWR);
    assign sub_osc_en  = osc_allow && ctrl0_q[C0_SUBON];

endmodule

// File: rtl/sysclk_mode_chk.sv
module sysclk_mode_chk
    import sysclk_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic             wr_en,
    input pwr_state_e       st,
    input logic [7:0]       ctrl0_q,
    input logic             bclk_en,
    input logic             main_osc_en,
    input logic             sub_osc_en,
    input logic             lat_sub,
    input logic [CNT_W-1:0] lat_term
);

    a_r8_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> (!bclk_en && !main_osc_en && !sub_osc_en));

    a_r8_resume_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESUME) |=> (st == ST_RUN));

    a_r9_stop_sets_div8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && stop_req && !ctrl0_q[7]) |=> ctrl0_q[6]);

    a_r10_stop_keeps_ctrl0: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && stop_req && ctrl0_q[7] && ctrl0_q[4] && !wr_en) |=> $stable(ctrl0_q));

    a_r5_lowpower_main_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0_q[7] && ctrl0_q[5] && ctrl0_q[4]) |-> !main_osc_en);

    a_r7_no_double_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && !lat_sub) |=> (!bclk_en || lat_sub || lat_term == '0));

endmodule

bind sysclk_mode_ctrl sysclk_mode_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .wr_en       (wr_en),
    .st          (st),
    .ctrl0_q     (ctrl0_q),
    .bclk_en     (bclk_en),
    .main_osc_en (main_osc_en),
    .sub_osc_en  (sub_osc_en),
    .lat_sub     (lat_sub),
    .lat_term    (lat_term)
);

// File: tb/sysclk_mode_ctrl_tb.sv
module sysclk_mode_ctrl_tb_top;

    localparam int SYNC_STAGES = 2;
    localparam int SUB_HALF    = 6;
    localparam int WATCHDOG    = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sub_clk_in = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake_in = 1'b0;
    logic       bclk_en, main_osc_en, sub_osc_en;
    logic [7:0] ctrl0_q, ctrl1_q;

    always #10 clk = ~clk;  // 50 MHz

    sysclk_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sub_clk_in(sub_clk_in), .stop_req(stop_req), .wake_in(wake_in),
        .bclk_en(bclk_en), .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
        .ctrl0_q(ctrl0_q), .ctrl1_q(ctrl1_q)
    );

    // ---------------- reference model ----------------
    // mode codes: 0 /1, 1 /2, 2 /4, 3 /8, 4 /16, 5 low-speed, 6 low-power
    bit [7:0] m_c0, m_c1;
    int       m_cnt, m_period, m_fsm;  // fsm: 0 run, 1 halted, 2 resuming
    bit       m_sub;
    bit       m_q[$];
    bit       m_last;

    function automatic int mdl_mode(bit [7:0] a, bit [7:0] b);
        if (a[7]) return !a[4] ? 3 : (a[5] ? 6 : 5);
        if (a[5] || a[6]) return 3;
        case (b[7:6])
            2'b00: return 0;
            2'b01: return 1;
            2'b10: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int mdl_period(int md);
        case (md)
            0: return 1;
            1: return 2;
            2: return 4;
            4: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic bit mdl_pulse();
        return m_q[SYNC_STAGES-1] && !m_last;
    endfunction

    task automatic mdl_reset();
        m_c0 = 8'h48; m_c1 = 8'h00; m_cnt = 0; m_period = 8; m_sub = 0;
        m_fsm = 0; m_last = 0;
        m_q.delete();
        for (int i = 0; i < SYNC_STAGES; i++) m_q.push_back(1'b0);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_reset();
        end else begin
            int  md;
            bit  bnd;
            bit  enter;
            md  = mdl_mode(m_c0, m_c1);
            bnd = m_sub ? mdl_pulse() : (m_cnt == m_period - 1);
            if (m_fsm != 0 || bnd) begin
                m_cnt = 0; m_period = mdl_period(md); m_sub = (md >= 5);
            end else if (!m_sub) begin
                m_cnt++;
            end
            m_last = m_q[SYNC_STAGES-1];
            m_q.push_front(sub_clk_in);
            void'(m_q.pop_back());
            enter = (m_fsm == 0) && stop_req;
            if (wr_en && !wr_sel) m_c0 = wr_data;
            if (wr_en && wr_sel)  m_c1 = wr_data;
            if (enter && md < 5) m_c0[6] = 1'b1;
            if (m_fsm == 0 && stop_req) m_fsm = 1;
            else if (m_fsm == 1 && wake_in) m_fsm = 2;
            else if (m_fsm == 2) m_fsm = 0;
        end
    end

    // ---------------- checking ----------------
    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    checking = 0;
    string cur_req = "R1";

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (checking) begin
            bit e_b;
            int md;
            md  = mdl_mode(m_c0, m_c1);
            e_b = (m_fsm == 0) && (m_sub ? mdl_pulse() : (m_cnt == m_period - 1));
            chk("bclk_en", {7'd0, bclk_en}, {7'd0, e_b});
            chk("main_osc_en", {7'd0, main_osc_en}, {7'd0, (m_fsm != 1) && (md != 6)});
            chk("sub_osc_en", {7'd0, sub_osc_en}, {7'd0, (m_fsm != 1) && m_c0[4]});
            chk("ctrl0_q", ctrl0_q, m_c0);
            chk("ctrl1_q", ctrl1_q, m_c1);
        end
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // sub-clock source, free running
    int sub_ctr = 0;
    always @(negedge clk) begin
        sub_ctr++;
        if (sub_ctr == SUB_HALF) begin
            sub_ctr = 0;
            sub_clk_in <= ~sub_clk_in;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(bit sel, bit [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_in(bit is_stop);
        @(negedge clk);
        if (is_stop) stop_req = 1'b1; else wake_in = 1'b1;
        @(negedge clk);
        stop_req = 1'b0; wake_in = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        checking = 1;
        // R1: reset values, /8 pulse train
        cur_req = "R1";  idle(40);
        // R2: divide-by-8 bit overrides divider select; R11 write of ctrl1
        cur_req = "R2";  write_reg(1'b1, 8'hC0); idle(40);
        // R3 / R7: clear divide-by-8, ctrl1=11 -> /16, change mid-period
        cur_req = "R3";  write_reg(1'b0, 8'h08); idle(45);
        cur_req = "R7";  write_reg(1'b1, 8'h40); idle(21);
        cur_req = "R3";  write_reg(1'b1, 8'h80); idle(23);
        cur_req = "R7";  write_reg(1'b1, 8'h00); idle(9);
        cur_req = "R3";  write_reg(1'b1, 8'hC0); idle(35);
        // R6: invalid encodings fall back to /8
        cur_req = "R6";  write_reg(1'b0, 8'h28); idle(30);
        cur_req = "R6";  write_reg(1'b0, 8'h80); idle(30);
        // R4: sub-clock source, low-speed; R11 write of ctrl0
        cur_req = "R4";  write_reg(1'b0, 8'h98); idle(80);
        // R5: low-power mode drops the main oscillator enable
        cur_req = "R5";  write_reg(1'b0, 8'hB8); idle(40);
        // R10 / R8: stop from sub-clock mode keeps ctrl0
        cur_req = "R10"; pulse_in(1'b1); idle(12);
        cur_req = "R8";  pulse_in(1'b0); idle(40);
        // R9: stop from a main-clock mode sets the divide-by-8 bit
        cur_req = "R9";  write_reg(1'b0, 8'h08); write_reg(1'b1, 8'h40); idle(15);
        pulse_in(1'b1); idle(10);
        cur_req = "R8";  pulse_in(1'b0); idle(40);
        // R11: ctrl1 write while running from main clock
        cur_req = "R11"; write_reg(1'b1, 8'h55); idle(10);
        checking = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule